// File: doc/BRIEF.md
# Synthetic Mesh Traffic Source

This block sits at one node of an 8-by-8 mesh and feeds the local injection port of that node's router. Every node has its own copy. Each copy is steered by a small set of inputs: its own X/Y position, a destination-pattern select, an injection-rate threshold, a hot-spot node with a hit probability, and a packet length. Together these produce repeatable, tunable synthetic load on the network.

When the generator is idle, it decides once per cycle whether to begin a packet. It compares a pseudo-random byte with the rate threshold. When it begins a packet, it computes the destination and latches it together with the length. It then presents head, body and tail flits on a valid/stall interface. A flit stays on the port until the router accepts it. A running count of completed packets is provided for the surrounding logic.

Top module: `noc_traffic_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `flitValid` is 0 and `pktCount` is 0.
- R2: The top two flit bits give the flit kind: 01 head, 00 body, 10 tail, 11 single-flit packet. A packet holds `pktLen` flits, and a `pktLen` of 0 is treated as 1.
- R3: A head or single flit carries the destination X in bits [2:0], destination Y in [5:3], source X in [8:6] and source Y in [11:9]. Every other flit carries its zero-based position in the packet in bits [3:0].
- R4: Pattern 01 (tornado) sends from node (x, y) to ((x + 3) mod 8, y).
- R5: Pattern 10 (transpose) sends from node (x, y) to node (y, x).
- R6: Pattern 00 (uniform) picks a pseudo-random destination that never equals the sending node.
- R7: Pattern 11 (hot-spot) picks the hot-spot node with probability `hotPct`/256. A `hotPct` of 255 means always. Otherwise it picks a uniform destination as in R6, so a `hotPct` of 0 never picks the hot-spot node.
- R8: An idle generator starts a packet with probability `injRate`/256 per cycle. A rate of 0 never starts one. A rate of 255 starts one on every idle cycle, which leaves exactly one idle cycle after each tail flit.
- R9: While `flitValid` is 1 and `flitStall` is 1, the flit and `flitValid` stay unchanged.
- R10: `pktCount` rises by one, in the cycle after the tail (or single) flit is accepted.
- R11: Pattern, length and position inputs are sampled only when a packet starts. Changing them mid-packet does not alter the packet in flight, and a new packet starts only after the previous tail flit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| myX | input | 3 | X position of this node |
| myY | input | 3 | Y position of this node |
| patternSel | input | 2 | Destination pattern: 00 uniform, 01 tornado, 10 transpose, 11 hot-spot |
| injRate | input | 8 | Injection threshold out of 256 (255 = every idle cycle) |
| hotX | input | 3 | Hot-spot node X |
| hotY | input | 3 | Hot-spot node Y |
| hotPct | input | 8 | Hot-spot probability out of 256 (255 = always) |
| pktLen | input | 4 | Flits per packet (0 treated as 1) |
| flitStall | input | 1 | Back-pressure from the router port |
| flitValid | output | 1 | A flit is presented |
| flitData | output | 32 | Flit contents, kind in the top two bits |
| pktCount | output | 16 | Completed packets, wrapping |

## Verification
The assertions assume that the node position does not change in the cycle a packet starts. The stimulus meets this by changing configuration only at falling edges while the generator is idle or mid-packet. They also assume that back-pressure appears only as a level, never as a stimulus that would drop a presented flit. The stimulus raises `flitStall` only while a flit is valid and lowers it again before moving on. The sweeps visit every node position for the deterministic patterns. Probability checks use wide bounds, because the pseudo-random sequence is fixed from reset but not modelled in the bench.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

  typedef enum logic [1:0] {
    PAT_UNIFORM   = 2'd0,
    PAT_TORNADO   = 2'd1,
    PAT_TRANSPOSE = 2'd2,
    PAT_HOTSPOT   = 2'd3
  } pattern_e;

  typedef enum logic [1:0] {
    KIND_BODY   = 2'b00,
    KIND_HEAD   = 2'b01,
    KIND_TAIL   = 2'b10,
    KIND_SINGLE = 2'b11
  } flit_kind_e;

  typedef struct packed {
    logic startPkt;
    logic nextFlit;
    logic endPkt;
  } strobe_t;

endpackage

// File: rtl/tgen_ctrl.sv
module tgen_ctrl
  import tgen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    injectReq,
  input  logic    lastFlit,
  input  logic    flitStall,
  output strobe_t strobes,
  output logic    flitValid
);

  typedef enum logic {ST_IDLE, ST_SEND} state_e;
  state_e stateQ;

  logic accept;

  always_comb begin
    accept           = (stateQ == ST_SEND) && !flitStall;
    strobes          = '0;
    strobes.startPkt = (stateQ == ST_IDLE) && injectReq;
    strobes.nextFlit = accept && !lastFlit;
    strobes.endPkt   = accept && lastFlit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
    end else begin
      case (stateQ)
        ST_IDLE: if (strobes.startPkt) stateQ <= ST_SEND;
        ST_SEND: if (strobes.endPkt)   stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign flitValid = (stateQ == ST_SEND);

  // R8 / R11: one idle cycle always follows an accepted tail
  assert_gap_after_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.endPkt |=> !flitValid);

  // R9: a stalled flit stays presented
  assert_valid_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flitValid && flitStall |=> flitValid);

  // R1: nothing presented straight out of reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !flitValid);

endmodule

// File: rtl/tgen_datapath.sv
module tgen_datapath
  import tgen_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int RATE_W  = 8,
  parameter int LEN_W   = 4,
  parameter int FLIT_W  = 32,
  parameter int CNT_W   = 16,
  parameter int LFSR_W  = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic [1:0]         patternSel,
  input  logic [RATE_W-1:0]  injRate,
  input  logic [COORD_W-1:0] hotX,
  input  logic [COORD_W-1:0] hotY,
  input  logic [RATE_W-1:0]  hotPct,
  input  logic [LEN_W-1:0]   pktLen,
  input  strobe_t            strobes,
  input  logic               flitValid,
  input  logic               flitStall,
  output logic               injectReq,
  output logic               lastFlit,
  output logic [FLIT_W-1:0]  flitData,
  output logic [CNT_W-1:0]   pktCount
);

  localparam logic [COORD_W-1:0] C_ONE    = COORD_W'(1);
  localparam logic [COORD_W-1:0] TORN_OFS = COORD_W'((1 << (COORD_W - 1)) - 1);
  localparam logic [LEN_W-1:0]   L_ONE    = LEN_W'(1);
  localparam logic [CNT_W-1:0]   N_ONE    = CNT_W'(1);
  localparam int HDR_W = 4 * COORD_W;

  logic [LFSR_W-1:0]  lfsrQ;
  logic [RATE_W-1:0]  rateRnd, hotRnd;
  logic [COORD_W-1:0] candX, candY, uniX, uniY, nxtX, nxtY;
  logic [COORD_W-1:0] destXQ, destYQ, srcXQ, srcYQ;
  logic [LEN_W-1:0]   lenQ, idxQ;
  logic [CNT_W-1:0]   countQ;
  logic               hotHit, isHead;
  flit_kind_e         kind;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsrQ <= LFSR_SEED;
    else if (lfsrQ[0]) lfsrQ <= (lfsrQ >> 1) ^ LFSR_TAPS;
    else lfsrQ <= lfsrQ >> 1;
  end

  always_comb begin
    rateRnd   = lfsrQ[RATE_W-1:0];
    hotRnd    = lfsrQ[LFSR_W-1 -: RATE_W];
    candX     = lfsrQ[LFSR_W-2 -: COORD_W];
    candY     = lfsrQ[LFSR_W-2-COORD_W -: COORD_W];
    injectReq = (injRate == '1) || (rateRnd < injRate);
    hotHit    = (hotPct == '1) || (hotRnd < hotPct);
    uniY      = candY;
    if (candX == myX && candY == myY) uniX = candX + C_ONE;
    else uniX = candX;
  end

  always_comb begin
    case (pattern_e'(patternSel))
      PAT_TORNADO: begin
        nxtX = myX + TORN_OFS;
        nxtY = myY;
      end
      PAT_TRANSPOSE: begin
        nxtX = myY;
        nxtY = myX;
      end
      PAT_HOTSPOT: begin
        nxtX = hotHit ? hotX : uniX;
        nxtY = hotHit ? hotY : uniY;
      end
      default: begin
        nxtX = uniX;
        nxtY = uniY;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      destXQ <= '0;
      destYQ <= '0;
      srcXQ  <= '0;
      srcYQ  <= '0;
      lenQ   <= L_ONE;
      idxQ   <= '0;
      countQ <= '0;
    end else begin
      if (strobes.startPkt) begin
        destXQ <= nxtX;
        destYQ <= nxtY;
        srcXQ  <= myX;
        srcYQ  <= myY;
        lenQ   <= (pktLen == '0) ? L_ONE : pktLen;
        idxQ   <= '0;
      end else if (strobes.nextFlit) begin
        idxQ <= idxQ + L_ONE;
      end
      if (strobes.endPkt) countQ <= countQ + N_ONE;
    end
  end

  always_comb begin
    isHead   = (idxQ == '0);
    lastFlit = (idxQ == lenQ - L_ONE);
    if (isHead) kind = lastFlit ? KIND_SINGLE : KIND_HEAD;
    else        kind = lastFlit ? KIND_TAIL   : KIND_BODY;
    flitData = '0;
    flitData[FLIT_W-1 -: 2] = kind;
    if (isHead) flitData[HDR_W-1:0] = {srcYQ, srcXQ, destYQ, destXQ};
    else        flitData[LEN_W-1:0] = idxQ;
  end

  assign pktCount = countQ;

  // R9: contents frozen under back-pressure
  assert_hold_flit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flitValid && flitStall |=> $stable(flitData));

  // R6: uniform never targets the sender
  assert_uniform_not_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.startPkt && patternSel == PAT_UNIFORM |=>
      !(destXQ == $past(myX) && destYQ == $past(myY)));

  // R5: transpose swaps the coordinates
  assert_transpose_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.startPkt && patternSel == PAT_TRANSPOSE |=>
      destXQ == $past(myY) && destYQ == $past(myX));

  // R10: count steps by one per completed packet
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.endPkt |=> pktCount == $past(pktCount) + N_ONE);

  // R2: flit position stays inside the latched length
  assert_index_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flitValid |-> idxQ < lenQ);

  // R11: latched length is frozen while a packet is in flight
  assert_len_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flitValid && !strobes.endPkt |=> $stable(lenQ));

endmodule

// File: rtl/noc_traffic_gen.sv
module noc_traffic_gen
  import tgen_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int RATE_W  = 8,
  parameter int LEN_W   = 4,
  parameter int FLIT_W  = 32,
  parameter int CNT_W   = 16
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] myX,
  input  logic [COORD_W-1:0] myY,
  input  logic [1:0]         patternSel,
  input  logic [RATE_W-1:0]  injRate,
  input  logic [COORD_W-1:0] hotX,
  input  logic [COORD_W-1:0] hotY,
  input  logic [RATE_W-1:0]  hotPct,
  input  logic [LEN_W-1:0]   pktLen,
  input  logic               flitStall,
  output logic               flitValid,
  output logic [FLIT_W-1:0]  flitData,
  output logic [CNT_W-1:0]   pktCount
);

  strobe_t strobes;
  logic    injectReq;
  logic    lastFlit;

  tgen_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .injectReq (injectReq),
    .lastFlit  (lastFlit),
    .flitStall (flitStall),
    .strobes   (strobes),
    .flitValid (flitValid)
  );

  tgen_datapath #(
    .COORD_W (COORD_W),
    .RATE_W  (RATE_W),
    .LEN_W   (LEN_W),
    .FLIT_W  (FLIT_W),
    .CNT_W   (CNT_W)
  ) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .myX        (myX),
    .myY        (myY),
    .patternSel (patternSel),
    .injRate    (injRate),
    .hotX       (hotX),
    .hotY       (hotY),
    .hotPct     (hotPct),
    .pktLen     (pktLen),
    .strobes    (strobes),
    .flitValid  (flitValid),
    .flitStall  (flitStall),
    .injectReq  (injectReq),
    .lastFlit   (lastFlit),
    .flitData   (flitData),
    .pktCount   (pktCount)
  );

endmodule

// File: tb/test_noc_traffic_gen.sv
module test_noc_traffic_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  myX = '0, myY = '0, hotX = '0, hotY = '0;
  logic [1:0]  patternSel = '0;
  logic [7:0]  injRate = '0, hotPct = '0;
  logic [3:0]  pktLen = 4'd1;
  logic        flitStall = 1'b0;
  logic        flitValid;
  logic [31:0] flitData;
  logic [15:0] pktCount;

  int checks = 0;
  int errors = 0;
  int lastDx, lastDy;

  always #10 clk = ~clk;

  noc_traffic_gen i_noc_traffic_gen (
    .clk(clk), .rst_n(rst_n), .myX(myX), .myY(myY), .patternSel(patternSel),
    .injRate(injRate), .hotX(hotX), .hotY(hotY), .hotPct(hotPct), .pktLen(pktLen),
    .flitStall(flitStall), .flitValid(flitValid), .flitData(flitData), .pktCount(pktCount)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expDx < 0 : destination only has to differ from the sender
  task automatic getPacket(input int expLen, input int expDx, input int expDy,
                           input int stallAt, input int changeLenTo, input string req);
    bit got = 0;
    int cnt0 = int'(pktCount);
    int sx = int'(myX);
    int sy = int'(myY);
    for (int i = 0; i < 60 && !got; i++) begin
      if (flitValid) got = 1;
      else @(negedge clk);
    end
    chk(got, "R8", "packet started", int'(got), 1);
    if (!got) return;
    for (int k = 0; k < expLen; k++) begin
      int expKind = (k == 0) ? ((expLen == 1) ? 3 : 1) : ((k == expLen - 1) ? 2 : 0);
      chk(flitValid == 1'b1, "R2", "valid during packet", int'(flitValid), 1);
      chk(int'(flitData[31:30]) == expKind, "R2", "flit kind", int'(flitData[31:30]), expKind);
      if (k == 0) begin
        lastDx = int'(flitData[2:0]);
        lastDy = int'(flitData[5:3]);
        if (expDx >= 0) begin
          chk(lastDx == expDx, req, "dest x", lastDx, expDx);
          chk(lastDy == expDy, req, "dest y", lastDy, expDy);
        end else begin
          chk(!(lastDx == sx && lastDy == sy), "R6", "dest equals source", lastDx * 8 + lastDy, -1);
        end
        chk(int'(flitData[8:6]) == sx, "R3", "src x", int'(flitData[8:6]), sx);
        chk(int'(flitData[11:9]) == sy, "R3", "src y", int'(flitData[11:9]), sy);
      end else begin
        chk(int'(flitData[3:0]) == k, "R3", "flit position", int'(flitData[3:0]), k);
      end
      if (k == 1 && changeLenTo >= 0) begin
        pktLen = 4'(changeLenTo);
        patternSel = 2'd2;
      end
      if (k == stallAt) begin
        logic [31:0] held = flitData;
        flitStall = 1'b1;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          chk(flitValid && flitData == held, "R9", "held under stall", int'(flitData[31:30]), int'(held[31:30]));
        end
        flitStall = 1'b0;
      end
      @(negedge clk);
    end
    chk(int'(pktCount) == ((cnt0 + 1) & 16'hFFFF), "R10", "packet count", int'(pktCount), cnt0 + 1);
    chk(flitValid == 1'b0, "R11", "idle after tail", int'(flitValid), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    int hits, c0, c1;
    bit quiet;
    repeat (4) @(negedge clk);
    chk(flitValid == 1'b0, "R1", "valid in reset", int'(flitValid), 0);
    chk(pktCount == 16'd0, "R1", "count in reset", int'(pktCount), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(flitValid == 1'b0 && pktCount == 16'd0, "R1", "first cycle after reset", int'(flitValid), 0);

    // R8: rate zero never injects
    quiet = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (flitValid) quiet = 0;
    end
    chk(quiet, "R8", "rate 0 stays silent", int'(!quiet), 0);

    // R4: tornado over every node, single flit
    injRate = 8'hFF; pktLen = 4'd1; patternSel = 2'd1;
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) begin
        myX = 3'(x); myY = 3'(y);
        getPacket(1, (x + 3) % 8, y, -1, -1, "R4");
      end

    // R5: transpose over every node, two flits
    patternSel = 2'd2; pktLen = 4'd2;
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) begin
        myX = 3'(x); myY = 3'(y);
        getPacket(2, y, x, (x + y) % 3 == 0 ? 1 : -1, -1, "R5");
      end

    // R6: uniform, three flits, stalls and mid-packet config change (R11)
    for (int i = 0; i < 64; i++) begin
      patternSel = 2'd0; pktLen = 4'd3;
      myX = 3'(i % 8); myY = 3'((i * 5) % 8);
      getPacket(3, -1, -1, i % 4, (i % 5 == 0) ? 7 : -1, "R6");
    end

    // R2: length zero behaves as one
    patternSel = 2'd0; pktLen = 4'd0;
    for (int i = 0; i < 8; i++) begin
      myX = 3'(i); myY = 3'(7 - i);
      getPacket(1, -1, -1, -1, -1, "R2");
    end

    // R7: hot-spot always, four flits
    patternSel = 2'd3; hotX = 3'd5; hotY = 3'd6; hotPct = 8'hFF; pktLen = 4'd4;
    for (int i = 0; i < 16; i++) begin
      myX = 3'(i % 8); myY = 3'(i / 2);
      getPacket(4, 5, 6, i % 4, -1, "R7");
    end

    // R7: hot-spot never, behaves as uniform
    hotPct = 8'h00; pktLen = 4'd1; myX = 3'd1; myY = 3'd2;
    hits = 0;
    for (int i = 0; i < 100; i++) begin
      getPacket(1, -1, -1, -1, -1, "R7");
      if (lastDx == 5 && lastDy == 6) hits++;
    end
    chk(hits < 20, "R7", "pct 0 hot hits bounded by uniform", hits, 0);

    // R7: half probability
    hotPct = 8'd128; hits = 0;
    for (int i = 0; i < 200; i++) begin
      getPacket(1, -1, -1, -1, -1, "R7");
      if (lastDx == 5 && lastDy == 6) hits++;
    end
    chk(hits > 50 && hits < 160, "R7", "pct 128 hot share", hits, 100);

    // R8: half rate, flits flow freely
    patternSel = 2'd1; injRate = 8'd128;
    c0 = int'(pktCount);
    repeat (2000) @(negedge clk);
    c1 = int'(pktCount);
    chk((c1 - c0) > 300 && (c1 - c0) < 950, "R8", "rate 128 packets per 2000 cycles", c1 - c0, 667);

    // R8: back to rate 0, drain and confirm silence
    injRate = 8'd0;
    repeat (4) @(negedge clk);
    quiet = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (flitValid) quiet = 0;
    end
    chk(quiet, "R8", "rate 0 after traffic", int'(!quiet), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule